// File: doc/BRIEF.md
# Three-Bank Phase-Aligned Clock Divider

This block turns a fast system clock and two tick streams into three banks of divided clocks (A, B and C) plus a feedback clock. Every output is a register toggled in the system clock domain, so the divided clocks come out as ordinary synchronous signals. A source selector picks either the oscillator tick or the reference tick. A prescaler then passes every selected tick, or only every second one. The three banks count the resulting prescaled pulses. Banks A and B each offer a pair of ratios, ÷2 and ÷4. Bank C offers ÷4 and ÷6.

All banks derive their outputs from one shared frame counter. The frame lasts as many prescaled pulses as the least common multiple of all bank periods, so every bank rises together at the start of each frame. Divide selects and the two-bit enable code are latched only at frame starts. At that point every bank has just finished a low phase, which means a ratio change or an enable change never cuts a pulse short. An active-low master reset clears all counters, holds every output low and drops the output-enable flag.

Top module: `mbank_clkdiv`

## Requirements
- R1: With `half_rate` = 0 every selected source tick is a prescaled pulse. With `half_rate` = 1 only every second selected tick is one, counted from reset or from the moment `half_rate` is raised.
- R2: Banks A and B each have a period of 2 prescaled pulses when their select is 0 and 4 when it is 1. In both cases the output is high for the first half of the period.
- R3: Bank C has a period of 4 prescaled pulses when `sel_c` = 0 and 6 when `sel_c` = 1. It is high for 2 or 3 pulses respectively, so the duty cycle is 50%.
- R4: The enable code `en_code` selects the running banks: 2'b00 runs A only, 2'b01 runs C only, 2'b10 runs A and B, and 2'b11 runs all three. A bank that is not enabled stays low.
- R5: When `use_osc` = 0, `ref_tick` drives the prescaler and `osc_tick` has no effect on the banks. When `use_osc` = 1 the roles are swapped.
- R6: While `mr_n` = 0 (or `rst` = 1), every clock output is low one edge later and `out_en` is 0. After release, `out_en` returns to 1 on the next edge.
- R7: `clk_fb` is `osc_tick` divided by 8, high for 4 ticks and low for 4. It is independent of `use_osc` and `half_rate`.
- R8: After a clear ends, the first prescaled pulse makes every enabled bank rise on the same clock edge. Every rise of any bank falls on a prescaled pulse.
- R9: Select and enable values are latched only at frame starts, which occur every 12 prescaled pulses. A bank finishes its current frame at the old ratio and never emits a high phase shorter than its half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mr_n | input | 1 | Active-low master clear of all dividers and outputs |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| use_osc | input | 1 | 1: oscillator ticks feed the prescaler; 0: reference ticks do |
| half_rate | input | 1 | 1: prescaler divides by 2; 0: by 1 |
| sel_a | input | 1 | Bank A ratio select (0: ÷2, 1: ÷4) |
| sel_b | input | 1 | Bank B ratio select (0: ÷2, 1: ÷4) |
| sel_c | input | 1 | Bank C ratio select (0: ÷4, 1: ÷6) |
| en_code | input | 2 | Bank enable code |
| clk_a | output | 1 | Bank A divided clock |
| clk_b | output | 1 | Bank B divided clock |
| clk_c | output | 1 | Bank C divided clock |
| clk_fb | output | 1 | Oscillator ÷8 feedback clock |
| out_en | output | 1 | Outputs enabled flag (0 while cleared) |

## Verification
The assertions assume three things. First, the tick inputs are single-cycle, level-sampled pulses in the system clock domain. Second, every control input changes only between clock edges. Third, a clear lasts at least one full edge, so the high-width and rise checks can ignore the cycle where a clear truncates a pulse. The stimulus follows these rules by driving every input on the falling clock edge. It runs the oscillator tick continuously and produces reference ticks from a counter with a fixed spacing. Every clear it issues is a whole number of cycles long.

// File: rtl/cdv_pkg.sv
package cdv_pkg;

    localparam int unsigned BANKS = 3;
    localparam int unsigned IDX_A = 0;
    localparam int unsigned IDX_B = 1;
    localparam int unsigned IDX_C = 2;

    typedef logic [BANKS-1:0] bank_mask_t;

    typedef enum logic [1:0] {
        EN_ONLY_A = 2'b00,
        EN_ONLY_C = 2'b01,
        EN_A_AND_B = 2'b10,
        EN_EVERY = 2'b11
    } en_code_e;

    // per-bank configuration latched at frame starts
    typedef struct packed {
        logic sel;
        logic en;
    } bank_cfg_t;

    function automatic bank_mask_t decode_enable(input logic [1:0] code);
        bank_mask_t m;
        m = '0;
        case (en_code_e'(code))
            EN_ONLY_A: m[IDX_A] = 1'b1;
            EN_ONLY_C: m[IDX_C] = 1'b1;
            EN_A_AND_B: begin
                m[IDX_A] = 1'b1;
                m[IDX_B] = 1'b1;
            end
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        for (int i = 0; i < 48; i++) begin
            if (y != 0) begin
                t = x % y;
                x = y;
                y = t;
            end
        end
        return x;
    endfunction

    function automatic int unsigned lcm_u(input int unsigned a, input int unsigned b);
        return (a / gcd_u(a, b)) * b;
    endfunction

endpackage

// File: rtl/cdv_src.sv
module cdv_src (
    input  logic clk,
    input  logic clear,
    input  logic osc_tick,
    input  logic ref_tick,
    input  logic use_osc,
    input  logic half_rate,
    output logic step
);
    logic src_tick;
    logic skip_q;

    always_comb begin
        src_tick = use_osc ? osc_tick : ref_tick;
        step     = src_tick & (~half_rate | skip_q);
    end

    always_ff @(posedge clk) begin
        if (clear)                      skip_q <= 1'b0;
        else if (!half_rate)            skip_q <= 1'b0;
        else if (src_tick)              skip_q <= ~skip_q;
    end

    // R1: at half rate two prescaled pulses are never back to back
    assert_half_rate_gap_R1: assert property (@(posedge clk) disable iff (clear)
        (step && half_rate) |=> !(step && half_rate));

endmodule

// File: rtl/cdv_phase.sv
module cdv_phase #(
    parameter int unsigned FRAME = 12,
    parameter int unsigned PH_W  = 4
) (
    input  logic            clk,
    input  logic            clear,
    input  logic            step,
    output logic [PH_W-1:0] nxt_phase,
    output logic            boundary
);
    localparam logic [PH_W-1:0] LAST = PH_W'(FRAME - 1);

    logic [PH_W-1:0] phase_q;

    always_comb begin
        nxt_phase = (phase_q == LAST) ? '0 : phase_q + 1'b1;
        boundary  = step && (phase_q == LAST);
    end

    // cleared to the last slot so the first pulse opens a new frame
    always_ff @(posedge clk) begin
        if (clear)     phase_q <= LAST;
        else if (step) phase_q <= nxt_phase;
    end

    assert_frame_wrap_R9: assert property (@(posedge clk) disable iff (clear)
        boundary |=> (phase_q == '0));

endmodule

// File: rtl/cdv_bank.sv
module cdv_bank
    import cdv_pkg::*;
#(
    parameter int unsigned HALF0 = 1,
    parameter int unsigned HALF1 = 2,
    parameter int unsigned PH_W  = 4
) (
    input  logic            clk,
    input  logic            clear,
    input  logic            step,
    input  logic            boundary,
    input  logic [PH_W-1:0] nxt_phase,
    input  bank_cfg_t       cfg_in,
    output logic            q
);
    localparam int unsigned PER0  = 2 * HALF0;
    localparam int unsigned PER1  = 2 * HALF1;
    localparam int unsigned HMAX  = (HALF1 > HALF0) ? HALF1 : HALF0;
    localparam int unsigned CW    = $clog2(HMAX + 1) + 1;

    bank_cfg_t   cfg_q;
    bank_cfg_t   cfg_use;
    logic        hi0;
    logic        hi1;
    logic        q_nxt;
    logic [CW-1:0] hcnt;

    always_comb begin
        cfg_use = boundary ? cfg_in : cfg_q;
        hi0     = ((32'(nxt_phase) % PER0) < HALF0);
        hi1     = ((32'(nxt_phase) % PER1) < HALF1);
        q_nxt   = cfg_use.en & (cfg_use.sel ? hi1 : hi0);
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            cfg_q <= '0;
            q     <= 1'b0;
        end else if (step) begin
            cfg_q <= cfg_use;
            q     <= q_nxt;
        end
    end

    // length of the current high phase, in prescaled pulses
    always_ff @(posedge clk) begin
        if (clear)                 hcnt <= '0;
        else if (step && q_nxt && !q) hcnt <= CW'(1);
        else if (step && q_nxt && q)  hcnt <= hcnt + 1'b1;
    end

    assert_high_width_R2_R3: assert property (@(posedge clk) disable iff (clear)
        ($fell(q) && !$past(clear)) |-> (32'(hcnt) == (cfg_q.sel ? HALF1 : HALF0)));

    assert_rise_on_step_R8: assert property (@(posedge clk) disable iff (clear)
        $rose(q) |-> $past(step));

endmodule

// File: rtl/cdv_fbdiv.sv
module cdv_fbdiv #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic clear,
    input  logic tick,
    output logic q
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    always_comb cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt <= LAST;
            q   <= 1'b0;
        end else if (tick) begin
            cnt <= cnt_nxt;
            q   <= (32'(cnt_nxt) < DIV / 2);
        end
    end

    assert_fb_moves_on_tick_R7: assert property (@(posedge clk) disable iff (clear)
        ($rose(q) || $fell(q)) |-> $past(tick));

endmodule

// File: rtl/mbank_clkdiv.sv
module mbank_clkdiv
    import cdv_pkg::*;
#(
    parameter int unsigned A_HALF_LO = 1,
    parameter int unsigned A_HALF_HI = 2,
    parameter int unsigned B_HALF_LO = 1,
    parameter int unsigned B_HALF_HI = 2,
    parameter int unsigned C_HALF_LO = 2,
    parameter int unsigned C_HALF_HI = 3,
    parameter int unsigned FB_DIV    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mr_n,
    input  logic       osc_tick,
    input  logic       ref_tick,
    input  logic       use_osc,
    input  logic       half_rate,
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       sel_c,
    input  logic [1:0] en_code,
    output logic       clk_a,
    output logic       clk_b,
    output logic       clk_c,
    output logic       clk_fb,
    output logic       out_en
);
    localparam int unsigned FRAME = lcm_u(
        lcm_u(lcm_u(2 * A_HALF_LO, 2 * A_HALF_HI), lcm_u(2 * B_HALF_LO, 2 * B_HALF_HI)),
        lcm_u(2 * C_HALF_LO, 2 * C_HALF_HI));
    localparam int unsigned PH_W = (FRAME > 2) ? $clog2(FRAME) : 1;
    localparam int unsigned HALF_LO [BANKS] = '{A_HALF_LO, B_HALF_LO, C_HALF_LO};
    localparam int unsigned HALF_HI [BANKS] = '{A_HALF_HI, B_HALF_HI, C_HALF_HI};

    logic            clear;
    logic            step;
    logic            boundary;
    logic [PH_W-1:0] nxt_phase;
    bank_mask_t      en_mask;
    bank_mask_t      sel_vec;
    bank_mask_t      bank_q;

    always_comb begin
        clear   = rst | ~mr_n;
        en_mask = decode_enable(en_code);
        sel_vec = {sel_c, sel_b, sel_a};
    end

    cdv_src u_src (
        .clk       (clk),
        .clear     (clear),
        .osc_tick  (osc_tick),
        .ref_tick  (ref_tick),
        .use_osc   (use_osc),
        .half_rate (half_rate),
        .step      (step)
    );

    cdv_phase #(.FRAME(FRAME), .PH_W(PH_W)) u_phase (
        .clk       (clk),
        .clear     (clear),
        .step      (step),
        .nxt_phase (nxt_phase),
        .boundary  (boundary)
    );

    generate
        for (genvar g = 0; g < BANKS; g++) begin : g_bank
            bank_cfg_t cfg_g;
            assign cfg_g = '{sel: sel_vec[g], en: en_mask[g]};
            cdv_bank #(
                .HALF0 (HALF_LO[g]),
                .HALF1 (HALF_HI[g]),
                .PH_W  (PH_W)
            ) u_bank (
                .clk       (clk),
                .clear     (clear),
                .step      (step),
                .boundary  (boundary),
                .nxt_phase (nxt_phase),
                .cfg_in    (cfg_g),
                .q         (bank_q[g])
            );
        end
    endgenerate

    cdv_fbdiv #(.DIV(FB_DIV)) u_fb (
        .clk   (clk),
        .clear (clear),
        .tick  (osc_tick),
        .q     (clk_fb)
    );

    always_ff @(posedge clk) begin
        out_en <= ~clear;
    end

    assign clk_a = bank_q[IDX_A];
    assign clk_b = bank_q[IDX_B];
    assign clk_c = bank_q[IDX_C];

    assert_master_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(mr_n) |-> (!out_en && !clk_a && !clk_b && !clk_c && !clk_fb));

endmodule

// File: tb/sim_mbank_clkdiv.sv
module sim_mbank_clkdiv;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_L    = 12;

    logic clk = 1'b0;
    logic rst, mr_n, osc_tick, ref_tick, use_osc, half_rate;
    logic sel_a, sel_b, sel_c;
    logic [1:0] en_code;
    logic clk_a, clk_b, clk_c, clk_fb, out_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int ref_gap = 0;
    int ref_cnt = 0;
    bit done    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbank_clkdiv u0 (
        .clk(clk), .rst(rst), .mr_n(mr_n), .osc_tick(osc_tick), .ref_tick(ref_tick),
        .use_osc(use_osc), .half_rate(half_rate), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c(sel_c), .en_code(en_code), .clk_a(clk_a), .clk_b(clk_b),
        .clk_c(clk_c), .clk_fb(clk_fb), .out_en(out_en)
    );

    always @(posedge clk) cyc++;

    // reference ticks: one every ref_gap cycles when ref_gap > 0
    always @(negedge clk) begin
        if (ref_gap > 0) begin
            ref_tick = (ref_cnt == 0);
            ref_cnt  = (ref_cnt + 1) % ref_gap;
        end else begin
            ref_tick = 1'b0;
        end
    end

    // ---------------- reference model (from the requirements) ----------------
    typedef struct packed { logic oe; logic fb; logic c; logic b; logic a; } exp_t;
    exp_t sbq[$];

    bit m_skip;
    int m_n, m_fbn;
    bit m_sel[3];
    bit m_en[3];
    bit m_q[3];
    bit m_fb, m_oe;

    function automatic int half_of(input int b, input bit s);
        if (b == 2) return s ? 3 : 2;
        return s ? 2 : 1;
    endfunction

    function automatic bit en_of(input int b, input logic [1:0] code);
        case (code)
            2'b00: return (b == 0);
            2'b01: return (b == 2);
            2'b10: return (b != 2);
            default: return 1'b1;
        endcase
    endfunction

    always @(posedge clk) begin
        bit clr, stick, pulse;
        exp_t e;
        clr  = rst || !mr_n;
        m_oe = !clr;
        if (clr) begin
            m_skip = 0; m_n = 0; m_fbn = 0; m_fb = 0;
            for (int b = 0; b < 3; b++) begin m_q[b] = 0; m_sel[b] = 0; m_en[b] = 0; end
        end else begin
            stick = use_osc ? osc_tick : ref_tick;
            pulse = stick && (!half_rate || m_skip);
            if (!half_rate) m_skip = 0;
            else if (stick) m_skip = !m_skip;
            if (pulse) begin
                m_n++;
                if ((m_n - 1) % FRAME_L == 0) begin
                    m_sel[0] = sel_a; m_sel[1] = sel_b; m_sel[2] = sel_c;
                    for (int b = 0; b < 3; b++) m_en[b] = en_of(b, en_code);
                end
                for (int b = 0; b < 3; b++) begin
                    int h;
                    h = half_of(b, m_sel[b]);
                    m_q[b] = m_en[b] && (((m_n - 1) % (2 * h)) < h);
                end
            end
            if (osc_tick) begin
                m_fbn++;
                m_fb = (((m_fbn - 1) % 8) < 4);
            end
        end
        e = '{oe: m_oe, fb: m_fb, c: m_q[2], b: m_q[1], a: m_q[0]};
        sbq.push_back(e);
    end

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        exp_t e;
        if (!done && sbq.size() > 0) begin
            e = sbq.pop_front();
            n_tests++;
            if (clk_a !== e.a) begin n_fail++; $display("FAIL R2 clk_a cyc %0d actual %b expected %b", cyc, clk_a, e.a); end
            else if (clk_b !== e.b) begin n_fail++; $display("FAIL R2 clk_b cyc %0d actual %b expected %b", cyc, clk_b, e.b); end
            else if (clk_c !== e.c) begin n_fail++; $display("FAIL R3 clk_c cyc %0d actual %b expected %b", cyc, clk_c, e.c); end
            else if (clk_fb !== e.fb) begin n_fail++; $display("FAIL R7 clk_fb cyc %0d actual %b expected %b", cyc, clk_fb, e.fb); end
            else if (out_en !== e.oe) begin n_fail++; $display("FAIL R6 out_en cyc %0d actual %b expected %b", cyc, out_en, e.oe); end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic getq(input int b);
        case (b)
            0: return clk_a;
            1: return clk_b;
            2: return clk_c;
            default: return clk_fb;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic next_rise(input int b, output int at);
        logic prev;
        prev = getq(b);
        at = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!prev && getq(b)) begin at = cyc; return; end
            prev = getq(b);
        end
    endtask

    task automatic measure(input int b, input int ep, input int eh, input string tag);
        int t0, hi;
        logic cur;
        next_rise(b, t0);
        hi = 0;
        for (int i = 0; i < 400; i++) begin
            cur = getq(b);
            if (cur) hi++;
            @(negedge clk);
            if (!cur && getq(b)) break;
        end
        check((cyc - t0) == ep, {tag, " period"}, cyc - t0, ep);
        check(hi == eh, {tag, " high"}, hi, eh);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual 0 expected 1");
        finish_run();
    end

    // ---------------- driver ----------------
    initial begin
        int ra, rb, rc, t0, t1, t2, t3;
        rst = 1; mr_n = 1; osc_tick = 1; use_osc = 1; half_rate = 0;
        sel_a = 0; sel_b = 1; sel_c = 1; en_code = 2'b11;
        repeat (3) @(negedge clk);
        // R6: reset state
        check({clk_a, clk_b, clk_c, clk_fb, out_en} == 5'b0, "R6 reset outputs",
              {clk_a, clk_b, clk_c, clk_fb, out_en}, 0);

        // R8: first rises coincide after release
        rst = 0;
        ra = -1; rb = -1; rc = -1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ra < 0 && clk_a) ra = cyc;
            if (rb < 0 && clk_b) rb = cyc;
            if (rc < 0 && clk_c) rc = cyc;
        end
        check(ra >= 0 && rb == ra, "R8 bank B first rise", rb, ra);
        check(ra >= 0 && rc == ra, "R8 bank C first rise", rc, ra);

        // R2 R3 R7 ratios at full rate
        measure(0, 2, 1, "R2 A div2");
        measure(1, 4, 2, "R2 B div4");
        measure(2, 6, 3, "R3 C div6 duty");
        measure(3, 8, 4, "R7 fb div8");

        sel_a = 1; sel_b = 0; sel_c = 0;
        repeat (30) @(negedge clk);
        measure(0, 4, 2, "R2 A div4");
        measure(1, 2, 1, "R2 B div2");
        measure(2, 4, 2, "R3 C div4");

        // R1: prescaler halves the rate
        half_rate = 1;
        repeat (40) @(negedge clk);
        measure(0, 8, 4, "R1 A div4 at half rate");
        measure(2, 8, 4, "R1 C div4 at half rate");
        measure(3, 8, 4, "R7 fb unaffected by half rate");

        // R5: reference ticks drive the banks
        half_rate = 0; ref_gap = 3; use_osc = 0;
        repeat (60) @(negedge clk);
        measure(0, 12, 6, "R5 A from ref ticks");
        measure(3, 8, 4, "R7 fb unaffected by bypass");
        use_osc = 1; ref_gap = 0;

        // R4: enable code table
        for (int code = 0; code < 4; code++) begin
            int rises[3];
            bit seen_hi[3];
            logic prev[3];
            en_code = 2'(code);
            repeat (30) @(negedge clk);
            for (int b = 0; b < 3; b++) begin rises[b] = 0; seen_hi[b] = 0; prev[b] = getq(b); end
            for (int i = 0; i < 24; i++) begin
                @(negedge clk);
                for (int b = 0; b < 3; b++) begin
                    if (getq(b)) seen_hi[b] = 1;
                    if (!prev[b] && getq(b)) rises[b]++;
                    prev[b] = getq(b);
                end
            end
            for (int b = 0; b < 3; b++) begin
                if (en_of(b, 2'(code))) check(rises[b] > 0, $sformatf("R4 code %0d bank %0d runs", code, b), rises[b], 1);
                else check(!seen_hi[b], $sformatf("R4 code %0d bank %0d held low", code, b), int'(seen_hi[b]), 0);
            end
        end

        // R6: master clear
        mr_n = 0;
        @(negedge clk);
        @(negedge clk);
        check({clk_a, clk_b, clk_c, clk_fb, out_en} == 5'b0, "R6 master clear outputs",
              {clk_a, clk_b, clk_c, clk_fb, out_en}, 0);

        // R9: select change waits for the frame start
        sel_a = 0; sel_b = 0; sel_c = 0; en_code = 2'b11;
        mr_n = 1;
        @(negedge clk);
        check(out_en == 1'b1, "R6 out_en after release", out_en, 1);
        next_rise(2, t0);
        sel_c = 1;
        next_rise(2, t1);
        next_rise(2, t2);
        next_rise(2, t3);
        check((t1 - t0) == 4, "R9 old ratio kept in frame first", t1 - t0, 4);
        check((t2 - t1) == 4, "R9 old ratio kept in frame second", t2 - t1, 4);
        check((t3 - t2) == 6, "R9 new ratio at frame start", t3 - t2, 6);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule